// File: doc/BRIEF.md
# Tick Timer with Mode Control

This block is the periodic tick source for a processor core. It holds two software-visible registers: a 32-bit control register and a 32-bit free-running count register. The control register carries a 28-bit period, an interrupt enable, a sticky pending flag and a 2-bit operating mode. While the timer runs, the count register advances by one per clock. A match fires when the low 28 count bits equal the period. Depending on the mode, the match then restarts the count from zero, stops the timer, or lets the count carry on.

Software writes either register through a one-cycle write strobe. It reads both registers as live values on the read outputs. A match with the enable set latches the pending flag, and the core sees pending AND enable on the interrupt line. Software acknowledges by writing the control register with the pending bit at 0. Writing 1 there keeps the flag as it is and never sets it. The counter starts or stops only when a control write really changes the mode field.

Top module: `tick_timer`

## Requirements
- R1: After reset the control read value is 0, the count reads 0, the interrupt line is low and the count does not advance.
- R2: Control register layout: period in bits 27:0, pending in bit 28, enable in bit 29, mode in bits 31:30 (00 off, 01 restart, 10 one-shot, 11 continuous). A control write stores period, enable and mode exactly as written.
- R3: A control write whose mode field differs from the stored one starts counting if the new mode is non-zero and stops it if the new mode is 00. A write that leaves the mode field equal keeps the run state unchanged, including a one-shot timer that has already stopped.
- R4: While running, the count rises by one per clock. It holds its value in any cycle that carries a write to either register, and in every cycle while stopped.
- R5: A count write loads the written value on the next edge. The count read output always shows the current count.
- R6: A match is count[27:0] equal to the period, in a running cycle with no write. A match sets pending when enable is 1 and leaves pending untouched when enable is 0.
- R7: In restart mode (01) the count after a match is 0.
- R8: In one-shot mode (10) a match stops counting, and the count keeps the matched value.
- R9: In continuous mode (11) a match does not disturb counting, and the count wraps from 0xFFFFFFFF to 0.
- R10: On a control write, pending bit 1 keeps the current pending value and pending bit 0 clears it. Software can never set pending.
- R11: The interrupt line is high exactly when pending and enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_count | input | 1 | Write strobe for the count register |
| wr_data | input | 32 | Write data for either register |
| ctrl_rd | output | 32 | Live control register value (period, pending, enable, mode) |
| count_rd | output | 32 | Live count value |
| tick_irq | output | 1 | Timer interrupt request to the core |

## Verification
The embedded assertions watch several rules on every clock. A count write must land. A stopped counter must hold still, and a restart match must return to zero. A one-shot match must drop the run state, and a continuous counter must wrap to zero. Pending must obey the keep/clear rule on control writes and may rise only from an enabled match. A same-mode write must leave the run state alone. Only the bench scenarios can show the full effect of these rules over time: the exact count sequence around each match in every mode, the freeze during write cycles, a stopped one-shot that a same-mode write leaves stopped but a mode change restarts, a match on low bits while the upper count bits are non-zero, and the interrupt line following pending and enable through acknowledge writes.

// File: rtl/tick_timer_pkg.sv
// Shared definitions for the tick timer: register geometry and mode codes.
package tick_timer_pkg;

    // Register width and period field width; pending, enable and mode sit above the period.
    localparam int TT_DATA_W   = 32;
    localparam int TT_PERIOD_W = 28;

    // Operating modes as stored in the top two bits of the control register.
    typedef enum logic [1:0] {
        TT_OFF     = 2'b00,
        TT_RESTART = 2'b01,
        TT_ONESHOT = 2'b10,
        TT_FREE    = 2'b11
    } tt_mode_e;

endpackage

// File: rtl/tt_ctrl.sv
// Control register of the tick timer.
// Holds period, enable, pending and mode, and the run flag of the counter.
// Assumes DATA_W == PERIOD_W + 4 (pending, enable and two mode bits above the period).
// A write has priority over a match that would fall in the same cycle; the
// counter reports no match during a write cycle.
module tt_ctrl
    import tick_timer_pkg::*;
#(
    parameter int DATA_W   = TT_DATA_W,
    parameter int PERIOD_W = TT_PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                hit,
    output tt_mode_e            mode,
    output logic                irq_en,
    output logic                pending,
    output logic [PERIOD_W-1:0] period,
    output logic                run
);

    localparam int PEND_POS = PERIOD_W;
    localparam int IE_POS   = PERIOD_W + 1;
    localparam int MODE_POS = PERIOD_W + 2;

    generate
        if (DATA_W != PERIOD_W + 4) begin : g_bad_geom
            $error("tt_ctrl: DATA_W must equal PERIOD_W + 4");
        end
    endgenerate

    tt_mode_e new_mode;
    logic     mode_change;

    // Decode the mode field of the incoming write and compare it with the stored mode.
    always_comb begin
        new_mode    = tt_mode_e'(wr_data[MODE_POS +: 2]);
        mode_change = (new_mode != mode);
    end

    // Stored fields: period, enable and mode change only on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= TT_OFF;
            irq_en <= 1'b0;
            period <= '0;
        end else if (wr) begin
            mode   <= new_mode;
            irq_en <= wr_data[IE_POS];
            period <= wr_data[PERIOD_W-1:0];
        end
    end

    // Pending flag: keep or clear on a write, set by an enabled match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wr) begin
            if (!wr_data[PEND_POS]) begin
                pending <= 1'b0;
            end
        end else if (hit && irq_en) begin
            pending <= 1'b1;
        end
    end

    // Run flag: follows real mode changes, and drops on a one-shot match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (wr) begin
            if (mode_change) begin
                run <= (new_mode != TT_OFF);
            end
        end else if (hit && (mode == TT_ONESHOT)) begin
            run <= 1'b0;
        end
    end

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_data[PEND_POS]) |=> !pending);                                  // R10
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_data[PEND_POS]) |=> (pending == $past(pending)));                // R10
    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(hit) && $past(irq_en)));                         // R6
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr && (mode == TT_ONESHOT)) |=> !run);                            // R8
    AST_SAME_MODE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wr_data[MODE_POS +: 2] == mode)) |=> (run == $past(run)));         // R3

endmodule

// File: rtl/tt_counter.sv
// Count register of the tick timer.
// Advances by one per clock while running. It freezes in any cycle that
// carries a register write and loads on a count write. It detects a match
// of the low PERIOD_W bits against the period and applies the mode's
// action on a match. Assumes PERIOD_W <= DATA_W.
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int DATA_W   = TT_DATA_W,
    parameter int PERIOD_W = TT_PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  tt_mode_e            mode,
    input  logic [PERIOD_W-1:0] period,
    input  logic                hold,
    input  logic                load,
    input  logic [DATA_W-1:0]   load_val,
    output logic [DATA_W-1:0]   count,
    output logic                hit
);

    logic step_en;
    logic cmp_eq;

    // Step qualifier and low-bit comparison against the period.
    always_comb begin
        step_en = run && !hold;
        cmp_eq  = (count[PERIOD_W-1:0] == period);
        hit     = step_en && cmp_eq;
    end

    // Count register: load, mode action on a match, or plain increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (hit) begin
            case (mode)
                TT_RESTART: count <= '0;
                TT_ONESHOT: count <= count;
                default:    count <= count + DATA_W'(1);
            endcase
        end else if (step_en) begin
            count <= count + DATA_W'(1);
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));                                      // R5
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));                                       // R4
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !load && (mode == TT_RESTART)) |=> (count == '0));                 // R7
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && (mode == TT_FREE) && (count == '1)) |=> (count == '0)); // R9

endmodule

// File: rtl/tick_timer.sv
// Tick timer top: control register plus counter.
// It assembles the control read value and drives the interrupt line.
// Both write strobes freeze counting for their cycle; a same-cycle write
// to both registers applies both.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int DATA_W   = TT_DATA_W,
    parameter int PERIOD_W = TT_PERIOD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_count,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] count_rd,
    output logic              tick_irq
);

    tt_mode_e            mode;
    logic                irq_en;
    logic                pending;
    logic [PERIOD_W-1:0] period;
    logic                run;
    logic                hit;
    logic                any_wr;

    // Any register write freezes the count for that cycle.
    always_comb any_wr = wr_ctrl || wr_count;

    tt_ctrl #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ctrl),
        .wr_data (wr_data),
        .hit     (hit),
        .mode    (mode),
        .irq_en  (irq_en),
        .pending (pending),
        .period  (period),
        .run     (run)
    );

    tt_counter #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mode     (mode),
        .period   (period),
        .hold     (any_wr),
        .load     (wr_count),
        .load_val (wr_data),
        .count    (count_rd),
        .hit      (hit)
    );

    // Read value of the control register and the interrupt request.
    always_comb begin
        ctrl_rd  = {mode, irq_en, pending, period};
        tick_irq = pending && irq_en;
    end

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_ctrl = 1'b0;
    logic        wr_count = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd;
    logic [31:0] count_rd;
    logic        tick_irq;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] ctl;
        logic [31:0] cnt;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    tick_timer i_tick_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_count (wr_count),
        .wr_data  (wr_data),
        .ctrl_rd  (ctrl_rd),
        .count_rd (count_rd),
        .tick_irq (tick_irq)
    );

    // Driver: one cycle of stimulus plus the state expected after its edge.
    task automatic step(input logic wc_ctl, input logic wc_cnt, input logic [31:0] d,
                        input logic [31:0] e_ctl, input logic [31:0] e_cnt,
                        input logic e_irq, input string tag);
        exp_t it;
        @(negedge clk);
        wr_ctrl  = wc_ctl;
        wr_count = wc_cnt;
        wr_data  = d;
        it.ctl = e_ctl; it.cnt = e_cnt; it.irq = e_irq; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(input logic [31:0] e_ctl, input logic [31:0] e_cnt,
                        input logic e_irq, input string tag);
        step(1'b0, 1'b0, 32'h0, e_ctl, e_cnt, e_irq, tag);
    endtask

    // Monitor: compare the outputs just after each edge with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                total++;
                if (ctrl_rd !== it.ctl || count_rd !== it.cnt || tick_irq !== it.irq) begin
                    bad++;
                    $display("FAIL %s: ctrl=%h count=%h irq=%b expected ctrl=%h count=%h irq=%b",
                             it.tag, ctrl_rd, count_rd, tick_irq, it.ctl, it.cnt, it.irq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset, counter idle
        idle(32'h0, 32'h0, 1'b0, "R1 reset");

        // R5 / R4 / R3: load, stopped, start continuous, same-mode write, stop
        step(1'b0, 1'b1, 32'd5, 32'h0, 32'd5, 1'b0, "R5 load");
        idle(32'h0, 32'd5, 1'b0, "R4 stopped holds");
        step(1'b1, 1'b0, 32'hC000_0064, 32'hC000_0064, 32'd5, 1'b0, "R2 R4 write freezes");
        for (int i = 1; i <= 3; i++)
            idle(32'hC000_0064, 32'd5 + 32'(i), 1'b0, "R4 increments");
        step(1'b1, 1'b0, 32'hC000_0064, 32'hC000_0064, 32'd8, 1'b0, "R3 same mode write");
        idle(32'hC000_0064, 32'd9, 1'b0, "R3 still running");
        step(1'b1, 1'b0, 32'h0, 32'h0, 32'd9, 1'b0, "R3 mode off");
        idle(32'h0, 32'd9, 1'b0, "R3 stopped");

        // R7 / R6 / R11 / R10: restart with enable, acknowledge, no software set
        step(1'b0, 1'b1, 32'd0, 32'h0, 32'd0, 1'b0, "R5 load zero");
        step(1'b1, 1'b0, 32'h6000_0003, 32'h6000_0003, 32'd0, 1'b0, "R2 restart mode");
        for (int i = 1; i <= 3; i++)
            idle(32'h6000_0003, 32'(i), 1'b0, "R4 count up");
        idle(32'h7000_0003, 32'd0, 1'b1, "R7 R6 R11 match");
        idle(32'h7000_0003, 32'd1, 1'b1, "R7 after restart");
        step(1'b1, 1'b0, 32'h7000_0003, 32'h7000_0003, 32'd1, 1'b1, "R10 keep pending");
        step(1'b1, 1'b0, 32'h6000_0003, 32'h6000_0003, 32'd1, 1'b0, "R10 R11 clear");
        idle(32'h6000_0003, 32'd2, 1'b0, "R4 resumes");
        step(1'b1, 1'b0, 32'h5000_0003, 32'h4000_0003, 32'd2, 1'b0, "R10 no software set");
        idle(32'h4000_0003, 32'd3, 1'b0, "R4 count");
        idle(32'h4000_0003, 32'd0, 1'b0, "R6 no pending without enable");

        // R8 / R3 / R9: one-shot stop, same-mode write, mode change restarts
        step(1'b1, 1'b0, 32'h0, 32'h0, 32'd0, 1'b0, "R3 stop");
        step(1'b1, 1'b0, 32'hA000_0002, 32'hA000_0002, 32'd0, 1'b0, "R3 one-shot start");
        idle(32'hA000_0002, 32'd1, 1'b0, "R4 count");
        idle(32'hA000_0002, 32'd2, 1'b0, "R4 count");
        idle(32'hB000_0002, 32'd2, 1'b1, "R8 match holds");
        idle(32'hB000_0002, 32'd2, 1'b1, "R8 stays stopped");
        step(1'b1, 1'b0, 32'hB000_0002, 32'hB000_0002, 32'd2, 1'b1, "R3 same mode no restart");
        idle(32'hB000_0002, 32'd2, 1'b1, "R3 still stopped");
        step(1'b1, 1'b0, 32'hF000_0002, 32'hF000_0002, 32'd2, 1'b1, "R3 mode change");
        idle(32'hF000_0002, 32'd3, 1'b1, "R9 match continues");

        // R9 / R6: wrap, and match on low bits with upper bits set
        step(1'b1, 1'b0, 32'h0, 32'h0, 32'd3, 1'b0, "R10 clear via off");
        step(1'b0, 1'b1, 32'hFFFF_FFFE, 32'h0, 32'hFFFF_FFFE, 1'b0, "R5 load high");
        step(1'b1, 1'b0, 32'hC000_0005, 32'hC000_0005, 32'hFFFF_FFFE, 1'b0, "R3 continuous");
        idle(32'hC000_0005, 32'hFFFF_FFFF, 1'b0, "R9 top");
        idle(32'hC000_0005, 32'h0, 1'b0, "R9 wrap");
        idle(32'hC000_0005, 32'h1, 1'b0, "R9 after wrap");
        step(1'b0, 1'b1, 32'h1000_0004, 32'hC000_0005, 32'h1000_0004, 1'b0, "R5 load while running");
        step(1'b1, 1'b0, 32'hE000_0005, 32'hE000_0005, 32'h1000_0004, 1'b0, "R2 enable on");
        idle(32'hE000_0005, 32'h1000_0005, 1'b0, "R4 count");
        idle(32'hF000_0005, 32'h1000_0006, 1'b1, "R6 low-bit match");
        idle(32'hF000_0005, 32'h1000_0007, 1'b1, "R11 irq held");

        @(negedge clk);
        wr_ctrl  = 1'b0;
        wr_count = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R1 queue drain: left=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule